// File: doc/BRIEF.md
# Host Channel Receive Status FIFO

This block is the receive queue of a host controller. It holds two kinds of entry in one word-wide store. A data entry is a status word followed by its payload words. A status-only entry is a single word that reports either a finished transfer or a halted channel on one channel. The write side pushes words one at a time and is stalled when the store is full. The block parses each status word as it is written, so it knows how many payload words follow.

Software drains the queue from the read side. It can look at the head status word without removing it (peek), or take it and advance (pop). After a data status word has been popped, the payload words come out through a separate data port. A level interrupt is raised while at least one fully written entry is waiting, and software can mask it. Per-channel one-cycle events are raised by reads rather than writes. Transfer-complete fires when the completion entry is first read, and channel-halted fires when the halt entry is popped.

Top module: `hc_rx_stat_fifo`

## Requirements
- R1: After reset the queue is empty: `wr_ready`=1, `stat_valid`=0, `data_valid`=0, `rxlvl_irq`=0, and all event bits are 0.
- R2: With the mask clear, `rxlvl_irq` is 1 exactly while at least one fully written entry has not been fully read. A data entry counts only once its last payload word has been written. The interrupt is 0 once the queue is drained.
- R3: While `irq_mask`=1, `rxlvl_irq` is 0. Clearing the mask while a complete entry is still waiting makes `rxlvl_irq` 1 again.
- R4: Status word fields are: channel in bits [3:0], byte count in [14:4], data PID in [16:15], status type in [20:17]. Type 4'b0010 is a data packet with ceil(byte count/4) payload words. Every other type has no payload.
- R5: A peek (`stat_peek`=1 while `stat_valid`=1) shows the head status word on `stat_word` and leaves the head unchanged.
- R6: A pop (`stat_pop`=1 while `stat_valid`=1) removes the head status word. After a data status is popped, `stat_valid`=0 and `data_valid`=1 until all of its payload words have been read through `data_rd`.
- R7: `data_rd` has no effect while a status word is at the head, and `stat_pop` has no effect while a payload word is at the head.
- R8: When an entry of type 4'b0011 on channel c is first peeked or popped, `xfer_done` equals the one-hot value 1<<c for exactly the next cycle. Later reads of the same entry raise no event.
- R9: Popping an entry of type 4'b0111 on channel c sets `halted` to 1<<c for exactly the next cycle. Peeking it raises no event.
- R10: When DEPTH words are stored, `wr_ready`=0 and a write is dropped. No stored word is ever overwritten.
- R11: Entries and payload words are read out in the order they were written.
- R12: A data status with byte count 0 is a complete one-word entry. It raises the interrupt at once, and after it is popped the next status word is at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word present |
| wr_word | input | 32 | Status or payload word to store |
| wr_ready | output | 1 | Space available; a write is taken when valid and ready |
| irq_mask | input | 1 | Masks the receive-level interrupt |
| rxlvl_irq | output | 1 | Receive-level interrupt (level) |
| stat_peek | input | 1 | Read head status word without removing it |
| stat_pop | input | 1 | Read and remove head status word |
| stat_word | output | 32 | Head status word (0 when none) |
| stat_valid | output | 1 | A status word is at the head |
| data_rd | input | 1 | Remove the head payload word |
| data_word | output | 32 | Head payload word (0 when none) |
| data_valid | output | 1 | A payload word is at the head |
| xfer_done | output | NCH | Per-channel transfer-complete pulse |
| halted | output | NCH | Per-channel channel-halted pulse |

## Verification
If the write-side payload counter is wrong, the block commits an entry too early or too late. This shows as `rxlvl_irq` rising on the wrong write, within one cycle. If the read-side counter is wrong, the block gets out of step with the stored words. A payload word then appears on `stat_word`, or a status word on `data_word`, at the very next read, and the scoreboard compare catches it. A wrong "already read" flag shows as a missing or doubled `xfer_done` pulse on the cycle after a peek. A wrong pointer shows as out-of-order words or a missed full condition when the store is filled to DEPTH.

// File: rtl/hc_rx_stat_fifo.sv
module hc_rx_stat_fifo #(
  parameter int DEPTH = 256,
  parameter int NCH   = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  input  logic [31:0]    wr_word,
  output logic           wr_ready,
  input  logic           irq_mask,
  output logic           rxlvl_irq,
  input  logic           stat_peek,
  input  logic           stat_pop,
  output logic [31:0]    stat_word,
  output logic           stat_valid,
  input  logic           data_rd,
  output logic [31:0]    data_word,
  output logic           data_valid,
  output logic [NCH-1:0] xfer_done,
  output logic [NCH-1:0] halted
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [3:0] T_DATA = 4'b0010;
  localparam logic [3:0] T_DONE = 4'b0011;
  localparam logic [3:0] T_HALT = 4'b0111;

  logic [31:0] mem [DEPTH];
  logic [AW:0] wr_ptr, cm_ptr, rd_ptr;
  logic [9:0]  wr_left, rd_left;
  logic        head_seen;

  wire [AW:0]  used    = wr_ptr - rd_ptr;
  wire         wr_fire = wr_valid && wr_ready;
  wire [3:0]   w_type  = wr_word[20:17];
  wire [11:0]  w_sum   = {1'b0, wr_word[14:4]} + 12'd3;
  wire [9:0]   w_words = w_sum[11:2];

  wire [31:0]  head    = mem[rd_ptr[AW-1:0]];
  wire [3:0]   h_type  = head[20:17];
  wire [3:0]   h_ch    = head[3:0];
  wire [11:0]  h_sum   = {1'b0, head[14:4]} + 12'd3;
  wire [9:0]   h_words = h_sum[11:2];
  wire         avail   = cm_ptr != rd_ptr;

  assign wr_ready   = used != FULL;
  assign stat_valid = avail && rd_left == 10'd0;
  assign data_valid = avail && rd_left != 10'd0;
  assign stat_word  = stat_valid ? head : 32'd0;
  assign data_word  = data_valid ? head : 32'd0;
  assign rxlvl_irq  = !irq_mask && avail;

  wire s_pop     = stat_pop && stat_valid;
  wire d_pop     = data_rd && data_valid;
  wire s_read    = s_pop || (stat_peek && stat_valid);
  wire done_fire = s_read && h_type == T_DONE && !head_seen;
  wire halt_fire = s_pop && h_type == T_HALT;

  always_ff @(posedge clk)
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= wr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cm_ptr  <= '0;
      wr_left <= '0;
    end else if (wr_fire) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (wr_left == 10'd0) begin
        if (w_type == T_DATA && w_words != 10'd0) wr_left <= w_words;
        else cm_ptr <= wr_ptr + 1'b1;
      end else begin
        wr_left <= wr_left - 1'b1;
        if (wr_left == 10'd1) cm_ptr <= wr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      rd_left   <= '0;
      head_seen <= 1'b0;
    end else begin
      if (s_pop) begin
        rd_ptr    <= rd_ptr + 1'b1;
        head_seen <= 1'b0;
        if (h_type == T_DATA) rd_left <= h_words;
      end else begin
        if (d_pop) begin
          rd_ptr  <= rd_ptr + 1'b1;
          rd_left <= rd_left - 1'b1;
        end
        if (stat_peek && stat_valid) head_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_done <= '0;
      halted    <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        xfer_done[i] <= done_fire && h_ch == 4'(i);
        halted[i]    <= halt_fire && h_ch == 4'(i);
      end
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= FULL);
  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_ptr));
  // R6
  head_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_valid && data_valid));
  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mask && stat_valid) |-> rxlvl_irq);
  // R7
  data_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !data_valid && !stat_pop) |=> $stable(rd_ptr));
  // R8
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_done));
  // R9
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted != '0) |-> $past(stat_pop));
endmodule

// File: tb/hc_rx_stat_fifo_tb_top.sv
module hc_rx_stat_fifo_tb_top;
  localparam int DEPTH = 256;
  localparam int NCH   = 16;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, irq_mask = 0, stat_peek = 0, stat_pop = 0, data_rd = 0;
  logic [31:0] wr_word = '0;
  logic wr_ready, rxlvl_irq, stat_valid, data_valid;
  logic [31:0] stat_word, data_word;
  logic [NCH-1:0] xfer_done, halted;

  hc_rx_stat_fifo #(.DEPTH(DEPTH), .NCH(NCH)) dut_i (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, mcount = 0;
  logic [31:0] exp_q[$];
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int ch, input int bc, input int pid, input int typ);
    return {11'd0, 4'(typ), 2'(pid), 11'(bc), 4'(ch)};
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1; wr_word = w;
    if (mcount < DEPTH) begin exp_q.push_back(w); mcount++; end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic peek(input string req);
    @(negedge clk);
    stat_peek = 1;
    chk(stat_valid && stat_word == exp_q[0], req, stat_word, exp_q[0]);
    @(negedge clk);
    stat_peek = 0;
  endtask

  task automatic pop_stat(input string req);
    logic [31:0] e;
    e = exp_q.pop_front(); mcount--;
    @(negedge clk);
    stat_pop = 1;
    chk(stat_valid && stat_word == e, req, stat_word, e);
    @(negedge clk);
    stat_pop = 0;
  endtask

  task automatic pop_data(input string req);
    logic [31:0] e;
    e = exp_q.pop_front(); mcount--;
    @(negedge clk);
    data_rd = 1;
    chk(data_valid && data_word == e, req, data_word, e);
    @(negedge clk);
    data_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready && !stat_valid && !data_valid && !rxlvl_irq && xfer_done == 0 && halted == 0,
        "R1", {wr_ready, stat_valid, data_valid, rxlvl_irq}, 32'h8);

    // R2 interrupt only after whole data entry is written (ch2, 5 bytes -> 2 words)
    wr(mk(2, 5, 1, 2));
    chk(!rxlvl_irq, "R2 status only", rxlvl_irq, 0);
    wr(32'hA1A1_0001);
    chk(!rxlvl_irq, "R2 one payload word", rxlvl_irq, 0);
    wr(32'hA1A1_0002);
    chk(rxlvl_irq, "R2 entry complete", rxlvl_irq, 1);

    // R3 masking
    @(negedge clk); irq_mask = 1;
    @(negedge clk);
    chk(!rxlvl_irq, "R3 masked", rxlvl_irq, 0);
    irq_mask = 0;
    @(negedge clk);
    chk(rxlvl_irq, "R3 unmask reasserts", rxlvl_irq, 1);

    // R5 peek twice keeps head
    peek("R5 first peek");
    peek("R5 second peek");
    chk(xfer_done == 0, "R8 data peek no event", xfer_done, 0);

    // R7 data_rd with status at head is ignored
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
    peek("R7 head after stray data_rd");

    // R6 pop data status then payload
    pop_stat("R6 pop data status");
    chk(!stat_valid && data_valid, "R6 payload at head", {stat_valid, data_valid}, 32'h1);
    @(negedge clk); stat_pop = 1;
    @(negedge clk); stat_pop = 0;
    chk(data_valid && data_word == exp_q[0], "R7 stray stat_pop", data_word, exp_q[0]);
    pop_data("R4 payload 1");
    pop_data("R4 payload 2");
    chk(!stat_valid && !data_valid && !rxlvl_irq, "R4 payload count / R2 drained",
        {stat_valid, data_valid, rxlvl_irq}, 0);

    // R12 zero-length data, then completion on ch5
    wr(mk(3, 0, 0, 2));
    chk(rxlvl_irq, "R12 zero-length commits", rxlvl_irq, 1);
    wr(mk(5, 0, 0, 3));
    pop_stat("R12 pop zero-length");
    chk(stat_valid && !data_valid, "R12 next status at head", {stat_valid, data_valid}, 32'h2);

    // R8 completion event on first read only
    peek("R8 peek completion");
    chk(xfer_done == 16'h0020, "R8 done pulse ch5", xfer_done, 32'h20);
    @(negedge clk);
    chk(xfer_done == 0, "R8 single cycle", xfer_done, 0);
    peek("R8 second peek");
    chk(xfer_done == 0, "R8 no repeat on peek", xfer_done, 0);
    pop_stat("R8 pop completion");
    chk(xfer_done == 0 && halted == 0, "R8 no repeat on pop", {xfer_done, halted}, 0);

    // R9 halt event on pop only (ch9)
    wr(mk(9, 0, 0, 7));
    peek("R9 peek halt");
    chk(halted == 0, "R9 peek no event", halted, 0);
    pop_stat("R9 pop halt");
    chk(halted == 16'h0200, "R9 halt pulse ch9", halted, 32'h200);

    // R11 mixed ordering
    wr(mk(1, 8, 2, 2)); wr(32'hB0B0_0001); wr(32'hB0B0_0002);
    wr(mk(1, 0, 0, 7));
    wr(mk(4, 1, 3, 2)); wr(32'hC0C0_0001);
    pop_stat("R11 pkt ch1"); pop_data("R11 ch1 w1"); pop_data("R11 ch1 w2");
    pop_stat("R11 halt ch1");
    chk(halted == 16'h0002, "R9 halt pulse ch1", halted, 32'h2);
    pop_stat("R11 pkt ch4"); pop_data("R11 ch4 w1");
    chk(!stat_valid && !data_valid, "R11 empty", {stat_valid, data_valid}, 0);

    // R10 fill to DEPTH
    for (int i = 0; i < DEPTH; i++)
      wr(mk(i % 16, i, 0, (i % 3 == 0) ? 3 : (i % 3 == 1) ? 7 : 6));
    chk(!wr_ready, "R10 full", wr_ready, 0);
    wr(32'hDEAD_BEEF);
    chk(!wr_ready, "R10 still full", wr_ready, 0);
    for (int i = 0; i < DEPTH; i++) pop_stat("R10/R11 drain order");
    chk(!stat_valid && wr_ready && !rxlvl_irq, "R10 empty after drain",
        {stat_valid, wr_ready, rxlvl_irq}, 32'h2);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule